// File: doc/BRIEF.md
# PCI Target Read Size Calculator

This block decides how much data a PCI target read pulls from on-chip SRAM. When the PCI target side presents a read command, the block takes the command code, the start address and the programmed cache-line size. It works out a transfer length in bytes and latches it. It then pulses a clear to the target read FIFO and raises a memory read request, which stays up until the memory side acknowledges it.

Once the request has been acknowledged, the block counts the DWORDs delivered to the bus. It stops accepting data exactly at the computed length, so nothing past that length is ever fetched. A disconnect is flagged when the final DWORD lands on a 64-byte address boundary.

The cache-line size is given in DWORDs. The length is chosen per command type and then limited in two ways: it is never more than one 64-byte segment, and it never runs past the end of the segment that holds the start address.

Top module: `rd_size_calc`

## Requirements
- R1: A plain memory read (command code 4'h6) fetches one DWORD, so `mem_bytes` is 4.
- R2: A memory read line (command code 4'hE) with a nonzero `line_dw` fetches `line_dw` DWORDs, so `mem_bytes` is 4*`line_dw` before the limits in R5 and R6.
- R3: A memory read multiple (command code 4'hC) with a nonzero `line_dw` fetches 2*`line_dw` DWORDs before the limits in R5 and R6.
- R4: A `line_dw` of zero makes line and multiple reads fetch one DWORD. Any other command code is treated as a one-DWORD read.
- R5: The transfer never exceeds 64 bytes. Any larger computed length becomes 64.
- R6: The transfer is shortened so that it ends no later than the next 64-byte boundary. The offset within the segment is `start_addr[5:2]` in DWORDs, and `start_addr[1:0]` is ignored.
- R7: The cycle after a command is accepted, `fifo_clear` is high for exactly one cycle, and `mem_req` rises in the following cycle.
- R8: `mem_req` stays high until a cycle in which `mem_ack` is high. While it is high, `mem_addr` (the start address with bits [1:0] cleared) and `mem_bytes` hold steady.
- R9: After the acknowledge, exactly `mem_bytes`/4 `beat` pulses are consumed. `last_beat` is high while one DWORD remains. After the final beat the block returns to idle with `cmd_ready` high. `beat` and `mem_ack` have no effect outside the states that use them, and `cmd_ready` is low while a command is in progress.
- R10: `seg_disc` is high together with `last_beat` exactly when the transfer ends on a 64-byte boundary.
- R11: During and right after reset, `cmd_ready` is high and `fifo_clear`, `mem_req`, `last_beat` and `seg_disc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A read command is presented |
| cmd_ready | output | 1 | Block is idle and takes the command this cycle |
| cmd_code | input | 4 | PCI read command code |
| start_addr | input | ADDR_W | Byte start address of the read |
| line_dw | input | LINE_W | Cache-line size in DWORDs |
| fifo_clear | output | 1 | One-cycle clear for the target read FIFO |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_ack | input | 1 | Memory side accepts the request |
| mem_addr | output | ADDR_W | DWORD-aligned request address |
| mem_bytes | output | $clog2(SEG_BYTES)+1 | Latched transfer length in bytes |
| beat | input | 1 | One DWORD handed to the PCI bus this cycle |
| last_beat | output | 1 | The next beat is the final one |
| seg_disc | output | 1 | Final beat lands on a 64-byte boundary; disconnect |

## Verification
The hardest cases to reach from the ports are the two where the length limits act together. In one, a multiple read with a large line size is first capped at 64 bytes and then shortened again by a start offset near the end of the segment. In the other, the final beat of a shortened transfer has to raise `seg_disc` while a transfer of the same length starting elsewhere must not. The stimulus covers both with directed commands at offsets 0, 12 and 15 DWORDs and with line sizes 0, 8 and 40. It then runs a long series of commands with random codes, addresses and line sizes. Throughout, `beat` and `mem_ack` toggle at random in every state, including idle and the clear cycle.

// File: rtl/rdsz_pkg.sv
package rdsz_pkg;
    localparam logic [3:0] CMD_MEM_RD  = 4'h6;
    localparam logic [3:0] CMD_RD_LINE = 4'hE;
    localparam logic [3:0] CMD_RD_MULT = 4'hC;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CLR  = 2'd1,
        ST_REQ  = 2'd2,
        ST_XFER = 2'd3
    } rd_state_e;
endpackage

// File: rtl/rdsz_sizer.sv
module rdsz_sizer #(
    parameter int LINE_W = 8,
    parameter int SEG_DW = 16,
    parameter int OFS_W  = $clog2(SEG_DW),
    parameter int CNT_W  = $clog2(SEG_DW) + 1
) (
    input  logic [3:0]        cmd_code,
    input  logic [LINE_W-1:0] line_dw,
    input  logic [OFS_W-1:0]  seg_ofs,
    output logic [CNT_W-1:0]  size_dw
);
    import rdsz_pkg::*;

    localparam int RAW_W = LINE_W + 1;

    logic [RAW_W-1:0] raw_dw;
    logic [CNT_W-1:0] capped_dw;
    logic [CNT_W-1:0] room_dw;

    // length requested by the command type
    always_comb begin
        raw_dw = RAW_W'(1);
        unique case (cmd_code)
            CMD_RD_LINE: if (line_dw != '0) raw_dw = {1'b0, line_dw};
            CMD_RD_MULT: if (line_dw != '0) raw_dw = {line_dw, 1'b0};
            default:     raw_dw = RAW_W'(1);
        endcase
    end

    // segment cap, then trim to the end of the current segment
    always_comb begin
        capped_dw = (raw_dw > RAW_W'(SEG_DW)) ? CNT_W'(SEG_DW) : raw_dw[CNT_W-1:0];
        room_dw   = CNT_W'(SEG_DW) - CNT_W'(seg_ofs);
        size_dw   = (capped_dw > room_dw) ? room_dw : capped_dw;
    end
endmodule

// File: rtl/rdsz_ctrl.sv
module rdsz_ctrl #(
    parameter int ADDR_W = 32,
    parameter int SEG_DW = 16,
    parameter int OFS_W  = $clog2(SEG_DW),
    parameter int CNT_W  = $clog2(SEG_DW) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  size_in,
    output logic              fifo_clear,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W+1:0]  mem_bytes,
    input  logic              beat,
    output logic              last_beat,
    output logic              seg_disc
);
    import rdsz_pkg::*;

    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-3:0] dwa;
        logic [CNT_W-1:0]  size;
        logic [CNT_W-1:0]  rem;
        logic              bnd;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic [OFS_W-1:0] in_ofs;

    assign in_ofs = start_addr[OFS_W+1:2];

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (cmd_valid) begin
                r_d.st   = ST_CLR;
                r_d.dwa  = start_addr[ADDR_W-1:2];
                r_d.size = size_in;
                r_d.rem  = size_in;
                r_d.bnd  = (CNT_W'(in_ofs) + size_in) == CNT_W'(SEG_DW);
            end
            ST_CLR:  r_d.st = ST_REQ;
            ST_REQ:  if (mem_ack) r_d.st = ST_XFER;
            ST_XFER: if (beat) begin
                r_d.rem = r_q.rem - 1'b1;
                if (r_q.rem == CNT_W'(1)) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, dwa: '0, size: '0, rem: '0, bnd: 1'b0};
        else        r_q <= r_d;
    end

    assign cmd_ready  = (r_q.st == ST_IDLE);
    assign fifo_clear = (r_q.st == ST_CLR);
    assign mem_req    = (r_q.st == ST_REQ);
    assign mem_addr   = {r_q.dwa, 2'b00};
    assign mem_bytes  = {r_q.size, 2'b00};
    assign last_beat  = (r_q.st == ST_XFER) && (r_q.rem == CNT_W'(1));
    assign seg_disc   = last_beat && r_q.bnd;

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_bytes));

    assert_clear_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(fifo_clear));

    assert_clear_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> !fifo_clear && mem_req);

    assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_bytes != '0) && (mem_bytes <= (CNT_W+2)'(SEG_DW*4)));

    assert_in_segment_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({1'b0, mem_addr[OFS_W+1:0]} + {1'b0, mem_bytes}) <= (CNT_W+3)'(SEG_DW*4));

    assert_disc_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_disc |-> last_beat);

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req && !fifo_clear && !last_beat);

    assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat && beat |=> cmd_ready);
endmodule

// File: rtl/rd_size_calc.sv
module rd_size_calc #(
    parameter int ADDR_W    = 32,
    parameter int LINE_W    = 8,
    parameter int SEG_BYTES = 64,
    localparam int SEG_DW   = SEG_BYTES / 4,
    localparam int OFS_W    = $clog2(SEG_DW),
    localparam int CNT_W    = $clog2(SEG_DW) + 1,
    localparam int BYTE_W   = $clog2(SEG_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [3:0]        cmd_code,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LINE_W-1:0] line_dw,
    output logic              fifo_clear,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_bytes,
    input  logic              beat,
    output logic              last_beat,
    output logic              seg_disc
);
    logic [CNT_W-1:0] size_dw;

    rdsz_sizer #(
        .LINE_W(LINE_W), .SEG_DW(SEG_DW), .OFS_W(OFS_W), .CNT_W(CNT_W)
    ) u_sizer (
        .cmd_code (cmd_code),
        .line_dw  (line_dw),
        .seg_ofs  (start_addr[OFS_W+1:2]),
        .size_dw  (size_dw)
    );

    rdsz_ctrl #(
        .ADDR_W(ADDR_W), .SEG_DW(SEG_DW), .OFS_W(OFS_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .start_addr (start_addr),
        .size_in    (size_dw),
        .fifo_clear (fifo_clear),
        .mem_req    (mem_req),
        .mem_ack    (mem_ack),
        .mem_addr   (mem_addr),
        .mem_bytes  (mem_bytes),
        .beat       (beat),
        .last_beat  (last_beat),
        .seg_disc   (seg_disc)
    );
endmodule

// File: tb/rd_size_calc_tb.sv
module rd_size_calc_tb;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [3:0]        cmd_code = 4'h0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LINE_W-1:0] line_dw = '0;
    logic              fifo_clear, mem_req, last_beat, seg_disc;
    logic              mem_ack = 1'b0;
    logic              beat = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [6:0]        mem_bytes;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // reference model state
    int    ms = 0;          // 0 idle, 1 clear, 2 request, 3 transfer
    int    m_bytes = 0;
    longint m_addr = 0;
    int    m_rem = 0;
    bit    m_bnd = 0;
    bit    m_acc = 0;
    string m_tag = "R1";

    rd_size_calc #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .SEG_BYTES(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .start_addr(start_addr), .line_dw(line_dw),
        .fifo_clear(fifo_clear), .mem_req(mem_req), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_bytes(mem_bytes), .beat(beat),
        .last_beat(last_beat), .seg_disc(seg_disc)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    // behavioural model, updated on every rising edge
    always @(posedge clk) begin
        cycles++;
        m_acc = 0;
        if (!rst_n) begin
            ms = 0;
        end else begin
            case (ms)
                0: if (cmd_valid) begin
                    int dw, room, ofs;
                    bit other;
                    other = 0;
                    if (cmd_code == 4'h6) dw = 1;
                    else if (cmd_code == 4'hE) dw = (line_dw == 0) ? 1 : int'(line_dw);
                    else if (cmd_code == 4'hC) dw = (line_dw == 0) ? 1 : 2 * int'(line_dw);
                    else begin dw = 1; other = 1; end
                    if (cmd_code == 4'h6) m_tag = "R1";
                    else if (other || line_dw == 0) m_tag = "R4";
                    else if (cmd_code == 4'hE) m_tag = "R2";
                    else m_tag = "R3";
                    if (dw > 16) begin dw = 16; m_tag = "R5"; end
                    ofs  = int'((start_addr >> 2) & 32'hF);
                    room = 16 - ofs;
                    if (dw > room) begin dw = room; m_tag = "R6"; end
                    m_bytes = dw * 4;
                    m_addr  = longint'(start_addr & ~32'h3);
                    m_rem   = dw;
                    m_bnd   = (ofs + dw) == 16;
                    m_acc   = 1;
                    ms = 1;
                end
                1: ms = 2;
                2: if (mem_ack) ms = 3;
                3: if (beat) begin
                    m_rem--;
                    if (m_rem == 0) ms = 0;
                end
                default: ms = 0;
            endcase
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R11 cmd_ready", cmd_ready, 1);
                chk("R11 mem_req", mem_req, 0);
                chk("R11 fifo_clear", fifo_clear, 0);
                chk("R11 last_beat", last_beat, 0);
                chk("R11 seg_disc", seg_disc, 0);
            end else begin
                chk("R9 cmd_ready", cmd_ready, ms == 0);
                chk("R7 fifo_clear", fifo_clear, ms == 1);
                chk("R8 mem_req", mem_req, ms == 2);
                if (ms >= 2) begin
                    chk({m_tag, " mem_bytes"}, mem_bytes, m_bytes);
                    chk("R8 mem_addr", mem_addr, m_addr);
                end
                chk("R9 last_beat", last_beat, (ms == 3) && (m_rem == 1));
                chk("R10 seg_disc", seg_disc, (ms == 3) && (m_rem == 1) && m_bnd);
            end
        end
    end

    // random handshakes on both sides, active in every state
    initial begin
        forever begin
            @(posedge clk); #2;
            mem_ack = ($urandom % 3) == 0;
            beat    = ($urandom % 3) != 0;
        end
    end

    task automatic issue(input logic [3:0] code, input logic [31:0] addr, input logic [7:0] ln);
        @(posedge clk); #2;
        cmd_code = code; start_addr = addr; line_dw = ln; cmd_valid = 1'b1;
        do begin
            @(posedge clk); #2;
        end while (!m_acc);
        cmd_valid = 1'b0;
        cmd_code = $urandom; start_addr = $urandom; line_dw = $urandom;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        // directed corners
        issue(4'h6, 32'h1000_0000, 8'd8);   // R1
        issue(4'h6, 32'h1000_003F, 8'd8);   // R1 ending on boundary, R10
        issue(4'hE, 32'h2000_0000, 8'd8);   // R2
        issue(4'hE, 32'h2000_0020, 8'd8);   // R2 ends at boundary, R10
        issue(4'hC, 32'h3000_0000, 8'd4);   // R3
        issue(4'hC, 32'h3000_0000, 8'd8);   // R3 full segment
        issue(4'hE, 32'h4000_0010, 8'd0);   // R4 zero line
        issue(4'hC, 32'h4000_0010, 8'd0);   // R4 zero line
        issue(4'h7, 32'h4000_0000, 8'd8);   // R4 other code
        issue(4'hE, 32'h5000_0000, 8'd40);  // R5
        issue(4'hC, 32'h5000_0000, 8'd40);  // R5
        issue(4'hC, 32'h6000_0030, 8'd4);   // R6 offset 12
        issue(4'hC, 32'h6000_003C, 8'd40);  // R5 and R6 offset 15
        issue(4'hE, 32'h6000_0032, 8'd2);   // R6 low bits ignored
        for (int i = 0; i < 300; i++) begin
            logic [3:0] c;
            case ($urandom % 4)
                0: c = 4'h6;
                1: c = 4'hE;
                2: c = 4'hC;
                default: c = $urandom;
            endcase
            issue(c, $urandom, (($urandom % 5) == 0) ? 8'd0 : 8'($urandom % 48));
            repeat ($urandom % 3) @(posedge clk);
        end
        repeat (40) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule